// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that serves eight multiplexed analog inputs. A one-cycle start request, together with a 3-bit channel number and a rate bit, begins a conversion. The block then steers the external input multiplexer, opens the sample window, and walks a trial code on the external DAC from the most significant bit down. At each trial it reads one comparator bit, and it ends by publishing the 8-bit code with a one-cycle done pulse.

All timing is counted in conversion-clock periods. The rate bit picks a conversion clock equal to the system clock or half of it. A full conversion always spans 27 such periods: 6 for sampling, 2 for hold settling, 16 for the eight trials (two periods each), and 3 for finishing and latching.

The controller is a six-state machine:
- `ST_IDLE` goes to `ST_SAMPLE` on an accepted start.
- `ST_SAMPLE` goes to `ST_HOLD` after its sixth period.
- `ST_HOLD` goes to `ST_SET` after its second period, seeding the trial code with the MSB.
- `ST_SET` goes to `ST_CMP` after one period, letting the DAC settle.
- `ST_CMP` decides the current bit and returns to `ST_SET` for the next lower bit. After bit 0 it goes to `ST_FINISH` instead.
- `ST_FINISH` goes to `ST_IDLE` after its third period, latching the result and pulsing done.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset, `result`, `dac_code` and `mux_sel` are 0, and `done` and `sample_en` are 0.
- R2: A start accepted in idle latches `ch_sel` into `mux_sel`, which holds that value through the conversion whatever `ch_sel` does afterwards.
- R3: `sample_en` is high for exactly 6×D system cycles, beginning in the cycle after the accepting edge, and `dac_code` is 0 throughout. D is 1 when the rate bit is 0 and 2 when it is 1.
- R4: `done` is high in the cycle that follows the 27×D-th rising edge after the edge that accepted the start.
- R5: `clk_half` = 0 selects a conversion clock equal to the system clock and `clk_half` = 1 selects half of it. The value is latched at start, so changes during a conversion have no effect.
- R6: Bits are tried from bit 7 down to bit 0. Each trial drives the bit as 1 over the bits already decided, and keeps it only if `cmp_in` = 1 (input at or above the trial level) at the end of that trial's second period. For an input level L, the result is min(L, 255).
- R7: Both 0x00 (input level 0) and 0xFF (input level 255 or above) are produced. The neighbouring codes 0x01 and 0xFE are also produced.
- R8: A start request while a conversion runs is ignored. The channel and the finish time are unchanged, and no second conversion follows.
- R9: `done` is a single system-cycle pulse. `result` changes only in the cycle `done` rises and otherwise holds.
- R10: The first trial code, visible 8×D cycles after the accepting edge, is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, accepted only in idle |
| ch_sel | input | 3 | Channel to convert, latched at start |
| clk_half | input | 1 | 0: conversion clock = system clock, 1: system clock / 2 |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| mux_sel | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample switch enable |
| dac_code | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Last conversion result |
| done | output | 1 | One-cycle pulse when `result` updates |

## Verification
The bench counts edges from the accepting edge to the done pulse and to the end of sampling at both rates. A wrong tick budget or a divider that starts out of phase would shift these by one or more cycles. Input levels 0, 1, 254, 255 and beyond full scale are converted: a design that tests with the wrong comparator sense, or never clears a rejected bit, would miss 0x00 or 0xFF. The channel and rate inputs are changed mid-conversion, and a second start is issued while busy. A design that failed to latch them, or restarted on the second request, would move `mux_sel`, change the finish time or start an extra sample window.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_HOLD   = 3'd2,
        ST_SET    = 3'd3,
        ST_CMP    = 3'd4,
        ST_FINISH = 3'd5
    } sar_state_t;

endpackage

// File: rtl/adc_conv_tick.sv
module adc_conv_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic half,
    output logic tick
);

    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (restart) begin
            phase_q <= 1'b0;
        end else if (run) begin
            phase_q <= ~phase_q;
        end
    end

    always_comb begin
        tick = run && (!half || phase_q);
    end

    AST_HALF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (run && half && tick) |=> !tick); // R5

endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS     = 8,
    parameter int CH_BITS      = 3,
    parameter int SAMPLE_TICKS = 6,
    parameter int HOLD_TICKS   = 2,
    parameter int FINISH_TICKS = 3,
    localparam int CNT_W = $clog2(SAMPLE_TICKS + HOLD_TICKS + FINISH_TICKS + 1),
    localparam int IDX_W = $clog2(RES_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CH_BITS-1:0] ch_sel,
    input  logic               clk_half,
    input  logic               tick,
    output logic               busy,
    output logic               start_acc,
    output logic [CH_BITS-1:0] chan_q,
    output logic               half_q,
    output logic               sample_en,
    output logic               seed,
    output logic               decide,
    output logic [IDX_W-1:0]   bit_idx,
    output logic               latch,
    output logic               done
);

    sar_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic               done_q;

    logic sample_last, hold_last, finish_last;

    always_comb begin
        sample_last = (cnt_q == CNT_W'(SAMPLE_TICKS - 1));
        hold_last   = (cnt_q == CNT_W'(HOLD_TICKS - 1));
        finish_last = (cnt_q == CNT_W'(FINISH_TICKS - 1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SAMPLE;
                    cnt_d   = '0;
                end
            end
            ST_SAMPLE: begin
                if (tick) begin
                    if (sample_last) begin
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (hold_last) begin
                        state_d = ST_SET;
                        cnt_d   = '0;
                        idx_d   = IDX_W'(RES_BITS - 1);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SET: begin
                if (tick) begin
                    state_d = ST_CMP;
                end
            end
            ST_CMP: begin
                if (tick) begin
                    if (idx_q == '0) begin
                        state_d = ST_FINISH;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_SET;
                        idx_d   = idx_q - 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                if (tick) begin
                    if (finish_last) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            chan_q  <= '0;
            half_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            done_q  <= latch;
            if (start_acc) begin
                chan_q <= ch_sel;
                half_q <= clk_half;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        start_acc = (state_q == ST_IDLE) && start;
        sample_en = (state_q == ST_SAMPLE);
        seed      = (state_q == ST_HOLD) && tick && hold_last;
        decide    = (state_q == ST_CMP) && tick;
        latch     = (state_q == ST_FINISH) && tick && finish_last;
        bit_idx   = idx_q;
        done      = done_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(chan_q) && $stable(half_q))); // R8

    AST_SAMPLE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> sample_en); // R3

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_BITS = 8,
    localparam int IDX_W = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                seed,
    input  logic                decide,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                cmp_in,
    input  logic                latch,
    input  logic                sample_en,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] result
);

    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] sar_q, sar_d;
    logic [RES_BITS-1:0] result_q;

    always_comb begin
        sar_d = sar_q;
        if (clear) begin
            sar_d = '0;
        end else if (seed) begin
            sar_d = MSB_ONE;
        end else if (decide) begin
            if (!cmp_in) begin
                sar_d[bit_idx] = 1'b0;
            end
            if (bit_idx != '0) begin
                sar_d[bit_idx - 1'b1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q    <= '0;
            result_q <= '0;
        end else begin
            sar_q <= sar_d;
            if (latch) begin
                result_q <= sar_q;
            end
        end
    end

    assign trial  = sar_q;
    assign result = result_q;

    AST_SAMPLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (sar_q == '0)); // R3

    AST_REJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !cmp_in) |=> !sar_q[$past(bit_idx)]); // R6

    AST_ACCEPT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cmp_in) |=> sar_q[$past(bit_idx)]); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(result_q)); // R9

    AST_SEED_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (sar_q == MSB_ONE)); // R10

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
    parameter int RES_BITS     = 8,
    parameter int CH_BITS      = 3,
    parameter int SAMPLE_TICKS = 6,
    parameter int HOLD_TICKS   = 2,
    parameter int FINISH_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CH_BITS-1:0]  ch_sel,
    input  logic                clk_half,
    input  logic                cmp_in,
    output logic [CH_BITS-1:0]  mux_sel,
    output logic                sample_en,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                done
);

    localparam int IDX_W      = $clog2(RES_BITS);
    localparam int TOTAL_TICK = SAMPLE_TICKS + HOLD_TICKS + 2 * RES_BITS + FINISH_TICKS;
    localparam int CYC_W      = $clog2(2 * TOTAL_TICK + 2);

    logic             tick, busy, start_acc, half_q;
    logic             seed, decide, latch;
    logic [IDX_W-1:0] bit_idx;

    adc_conv_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (start_acc),
        .half    (half_q),
        .tick    (tick)
    );

    adc_sar_fsm #(
        .RES_BITS     (RES_BITS),
        .CH_BITS      (CH_BITS),
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .HOLD_TICKS   (HOLD_TICKS),
        .FINISH_TICKS (FINISH_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ch_sel    (ch_sel),
        .clk_half  (clk_half),
        .tick      (tick),
        .busy      (busy),
        .start_acc (start_acc),
        .chan_q    (mux_sel),
        .half_q    (half_q),
        .sample_en (sample_en),
        .seed      (seed),
        .decide    (decide),
        .bit_idx   (bit_idx),
        .latch     (latch),
        .done      (done)
    );

    adc_sar_reg #(
        .RES_BITS (RES_BITS)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_acc),
        .seed      (seed),
        .decide    (decide),
        .bit_idx   (bit_idx),
        .cmp_in    (cmp_in),
        .latch     (latch),
        .sample_en (sample_en),
        .trial     (dac_code),
        .result    (result)
    );

    // conversion-length checker: system cycles since the accepting edge
    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (start_acc) begin
            cyc_q <= '0;
        end else if (busy) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_q == (half_q ? CYC_W'(2 * TOTAL_TICK) : CYC_W'(TOTAL_TICK)))); // R4

endmodule

// File: tb/adc_sar_sequencer_bench.sv
module adc_sar_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [2:0] ch_sel;
    logic       clk_half;
    logic       cmp_in;
    logic [2:0] mux_sel;
    logic       sample_en;
    logic [7:0] dac_code;
    logic [7:0] result;
    logic       done;

    int chan_level [8];
    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk; // 125 MHz

    // behavioural comparator behind the analog multiplexer
    always_comb cmp_in = (chan_level[mux_sel] >= int'(dac_code));

    adc_sar_sequencer u_adc_sar_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ch_sel    (ch_sel),
        .clk_half  (clk_half),
        .cmp_in    (cmp_in),
        .mux_sel   (mux_sel),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .result    (result),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(result == 8'h00 && done == 1'b0, "R1 result/done", int'(result) + 256 * int'(done), 0);
        chk(sample_en == 1'b0 && dac_code == 8'h00, "R1 sample_en/dac_code",
            int'(dac_code) + 256 * int'(sample_en), 0);
        chk(mux_sel == 3'd0, "R1 mux_sel", int'(mux_sel), 0);
    endtask

    // one conversion, every timing and value check inside
    task automatic run_conv(input int ch, input bit half, input int lvl, input bit poke);
        int d;
        int exp_res;
        int done_at;
        int samp;
        bit dac_bad;
        logic [7:0] held;
        d       = half ? 2 : 1;
        exp_res = (lvl > 255) ? 255 : lvl;
        done_at = -1;
        samp    = 0;
        dac_bad = 1'b0;
        chan_level[ch] = lvl;
        @(negedge clk);
        start    = 1'b1;
        ch_sel   = 3'(ch);
        clk_half = half;
        @(posedge clk);          // accepting edge
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= 27 * d + 2 && done_at < 0; n++) begin
            if (n > 0) @(negedge clk);
            if (sample_en) begin
                samp++;
                if (dac_code != 8'h00) dac_bad = 1'b1;
            end
            if (n == 0) chk(mux_sel == 3'(ch), "R2 channel latched", int'(mux_sel), ch);
            if (n == 3) begin
                ch_sel   = 3'(ch + 5);
                clk_half = ~half;   // R5: must not alter this conversion
            end
            if (poke && n == 10) begin
                start  = 1'b1;
                ch_sel = 3'(ch + 1);
            end
            if (poke && n == 11) start = 1'b0;
            if (n == 8 * d) chk(dac_code == 8'h80, "R10 first trial code", int'(dac_code), 128);
            if (done) done_at = n;
        end
        chk(done_at == 27 * d, half ? "R4 R5 done timing half rate" : "R4 R5 done timing full rate",
            done_at, 27 * d);
        chk(samp == 6 * d, "R3 sample window length", samp, 6 * d);
        chk(!dac_bad, "R3 dac_code zero while sampling", int'(dac_bad), 0);
        chk(result == 8'(exp_res), "R6 R7 result code", int'(result), exp_res);
        chk(mux_sel == 3'(ch), poke ? "R8 channel kept" : "R2 channel held", int'(mux_sel), ch);
        held = result;
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        chan_level[ch] = 255 - exp_res;
        ch_sel = 3'(ch + 2);
        repeat (4) @(negedge clk);
        chk(result == held, "R9 result holds", int'(result), int'(held));
        chk(sample_en == 1'b0, poke ? "R8 no second conversion" : "R9 idle after done",
            int'(sample_en), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) chan_level[i] = 0;
        rst_n    = 1'b0;
        start    = 1'b0;
        ch_sel   = 3'd0;
        clk_half = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();                       // R1
        run_conv(2, 1'b0, 173, 1'b0);    // R2 R3 R4 R6
        run_conv(5, 1'b1, 90,  1'b0);    // R5 half rate
        run_conv(0, 1'b0, 0,   1'b0);    // R7 zero code
        run_conv(7, 1'b1, 255, 1'b0);    // R7 full-scale code
        run_conv(3, 1'b0, 400, 1'b0);    // R7 over range clamps to 0xFF
        run_conv(1, 1'b0, 1,   1'b0);    // R7 0x01
        run_conv(6, 1'b1, 254, 1'b0);    // R7 0xFE
        run_conv(4, 1'b0, 85,  1'b1);    // R8 start while busy
        run_conv(4, 1'b1, 170, 1'b1);    // R8 at half rate
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule